// File: doc/BRIEF.md
# Smart Card Reset Release Sequencer

This block owns the active-low reset line of a smart card slot. It keeps the card in reset while the slot is unpowered, while the supply has not yet been reported good, and while firmware asks for reset through a hold bit. Once the supply is good and the hold bit is clear, the line is released after a programmable number of elementary time units (ETUs). The delay may be zero, in which case the release follows supply-good or the clearing of the hold bit on the next clock edge. A firmware sequence that sets the hold bit before power is applied can bring the card up and keep it in reset until software decides to release it.

The block is a four-state machine. OFF is the unpowered state, HOLD is firmware-held reset, COUNT is the ETU delay, and RELEASED means reset is high. These transitions are taken:
- OFF to HOLD when power becomes good with the hold bit set.
- OFF to COUNT when power becomes good with the hold bit clear and a non-zero delay.
- OFF to RELEASED when power becomes good with the hold bit clear and a zero delay.
- HOLD to COUNT or to RELEASED when the hold bit clears. The choice depends on the delay, as above.
- COUNT to RELEASED on the ETU tick that ends the delay.
- COUNT to HOLD and RELEASED to HOLD when the hold bit is set.
- Any state to OFF when power is lost.

Each release raises a one-cycle strobe. This strobe starts the first-character timer further downstream.

Top module: `card_reset_sequencer`

## Requirements
- R1: While the reset input is active, and on the cycle after any edge at which supply_en or supply_ok is low, card_rst_n is 0. Power loss returns the machine to OFF in one cycle from any state.
- R2: Take delay_etu = 0 and hold_req = 0. If supply_en and supply_ok are first seen high together at a clock edge, card_rst_n is 1 from that edge on.
- R3: Take a delay of N > 0. Once the machine enters COUNT, card_rst_n rises at the edge that samples the N-th etu_tick after entry. A tick sampled on the entry edge itself is not counted.
- R4: If hold_req is 1 at a clock edge, card_rst_n is 0 after that edge, whatever the state.
- R5: If hold_req clears while power is good, reset is released after the programmed delay, timed as in R2 for zero and as in R3 for N.
- R6: If hold_req is set before power is applied, card_rst_n stays 0 through power-up and for as long as hold_req stays 1.
- R7: Setting hold_req during COUNT aborts the count and moves the machine to HOLD. Clearing hold_req later restarts the full delay.
- R8: release_pulse is 1 for exactly one cycle, the first cycle in which card_rst_n is 1 after having been 0. It is 0 at all other times.
- R9: delay_etu is captured when COUNT is entered. Changes to delay_etu during COUNT do not alter when the release happens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| supply_en | input | 1 | Card supply enable request |
| supply_ok | input | 1 | Card supply reported good |
| hold_req | input | 1 | Firmware reset-hold bit |
| delay_etu | input | 8 | Release delay in ETUs |
| etu_tick | input | 1 | One-cycle pulse per elapsed ETU |
| card_rst_n | output | 1 | Card reset pin level, low = reset |
| release_pulse | output | 1 | One-cycle strobe when reset is released |

## Verification
The assertions assume that every input is synchronous to clk and stable around each edge. They also assume that etu_tick is a level sampled once per edge, and that delay_etu may change at any time. The stimulus keeps to these assumptions by driving every input on the falling edge. The random phase changes supply and hold state only occasionally, so that the count, abort and release paths are all reached. It also varies the delay and tick density, including changes to the delay while a count is running.

// File: rtl/card_reset_pkg.sv
package card_reset_pkg;
    typedef enum logic [1:0] {
        ST_OFF      = 2'd0,
        ST_HOLD     = 2'd1,
        ST_COUNT    = 2'd2,
        ST_RELEASED = 2'd3
    } rst_state_e;
endpackage

// File: rtl/rst_delay_counter.sv
module rst_delay_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic             last
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (dec && cnt_q != '0) begin
            cnt_q <= cnt_q - ONE;
        end
    end

    assign last = (cnt_q == ONE);

    // R9: the delay is captured at COUNT entry
    a_r9_load_capture: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt_q == $past(load_val)));

    a_r9_hold_without_dec: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !dec) |=> $stable(cnt_q));
endmodule

// File: rtl/rst_seq_fsm.sv
module rst_seq_fsm
    import card_reset_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       power_good,
    input  logic       hold_req,
    input  logic       delay_zero,
    input  logic       etu_tick,
    input  logic       cnt_last,
    output logic       load_cnt,
    output logic       dec_cnt,
    output logic       card_rst_n,
    output logic       release_pulse
);
    rst_state_e state_q, state_d;

    // the next-state decision
    always_comb begin
        state_d = state_q;
        if (!power_good) begin
            state_d = ST_OFF;
        end else begin
            unique case (state_q)
                ST_OFF, ST_HOLD: begin
                    if (hold_req)        state_d = ST_HOLD;
                    else if (delay_zero) state_d = ST_RELEASED;
                    else                 state_d = ST_COUNT;
                end
                ST_COUNT: begin
                    if (hold_req)                  state_d = ST_HOLD;
                    else if (etu_tick && cnt_last) state_d = ST_RELEASED;
                end
                ST_RELEASED: begin
                    if (hold_req) state_d = ST_HOLD;
                end
                default: state_d = ST_OFF;
            endcase
        end
    end

    // the state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    // the registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            card_rst_n    <= 1'b0;
            release_pulse <= 1'b0;
        end else begin
            card_rst_n    <= (state_d == ST_RELEASED);
            release_pulse <= (state_d == ST_RELEASED) && (state_q != ST_RELEASED);
        end
    end

    assign load_cnt = (state_d == ST_COUNT) && (state_q != ST_COUNT);
    assign dec_cnt  = (state_q == ST_COUNT) && etu_tick;

    a_r1_power_loss_off: assert property (@(posedge clk) disable iff (!rst_n)
        !power_good |=> (!card_rst_n && state_q == ST_OFF));

    a_r4_hold_drives_low: assert property (@(posedge clk) disable iff (!rst_n)
        hold_req |=> !card_rst_n);

    a_r7_abort_to_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_COUNT && hold_req && power_good) |=> state_q == ST_HOLD);

    a_r3_wait_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_COUNT && !etu_tick && power_good && !hold_req) |=> state_q == ST_COUNT);

    a_r8_pulse_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(card_rst_n) |-> release_pulse);

    a_r8_pulse_only_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        release_pulse |-> (card_rst_n && !$past(card_rst_n)));
endmodule

// File: rtl/card_reset_sequencer.sv
module card_reset_sequencer #(
    parameter int DELAY_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               supply_en,
    input  logic               supply_ok,
    input  logic               hold_req,
    input  logic [DELAY_W-1:0] delay_etu,
    input  logic               etu_tick,
    output logic               card_rst_n,
    output logic               release_pulse
);
    logic power_good;
    logic load_cnt;
    logic dec_cnt;
    logic cnt_last;
    logic delay_zero;

    assign power_good = supply_en && supply_ok;
    assign delay_zero = (delay_etu == '0);

    rst_delay_counter #(.CNT_W(DELAY_W)) i_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load_cnt),
        .load_val (delay_etu),
        .dec      (dec_cnt),
        .last     (cnt_last)
    );

    rst_seq_fsm i_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .power_good    (power_good),
        .hold_req      (hold_req),
        .delay_zero    (delay_zero),
        .etu_tick      (etu_tick),
        .cnt_last      (cnt_last),
        .load_cnt      (load_cnt),
        .dec_cnt       (dec_cnt),
        .card_rst_n    (card_rst_n),
        .release_pulse (release_pulse)
    );

    a_r6_no_release_unpowered: assert property (@(posedge clk) disable iff (!rst_n)
        card_rst_n |-> $past(power_good));
endmodule

// File: tb/test_card_reset_sequencer.sv
module test_card_reset_sequencer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       supply_en = 1'b0;
    logic       supply_ok = 1'b0;
    logic       hold_req = 1'b0;
    logic [7:0] delay_etu = 8'd0;
    logic       etu_tick = 1'b0;
    logic       card_rst_n;
    logic       release_pulse;

    int n_checks = 0;
    int n_fails  = 0;
    string cur_req = "R1";
    bit done = 1'b0;

    always #10 clk = ~clk;

    card_reset_sequencer i_card_reset_sequencer (
        .clk(clk), .rst_n(rst_n), .supply_en(supply_en), .supply_ok(supply_ok),
        .hold_req(hold_req), .delay_etu(delay_etu), .etu_tick(etu_tick),
        .card_rst_n(card_rst_n), .release_pulse(release_pulse)
    );

    // reference model: 0 OFF, 1 HOLD, 2 COUNT, 3 RELEASED
    int m_state = 0;
    int m_cnt = 0;
    bit m_pulse = 1'b0;

    function automatic int f_next(int st, bit pg, bit hold, int dly, bit tick, int cnt);
        if (!pg) return 0;
        if (hold) return 1;
        if (st == 0 || st == 1) return (dly == 0) ? 3 : 2;
        if (st == 2) return (tick && cnt == 1) ? 3 : 2;
        return 3;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_state <= 0; m_cnt <= 0; m_pulse <= 1'b0;
        end else begin
            int nx;
            nx = f_next(m_state, supply_en && supply_ok, hold_req, int'(delay_etu), etu_tick, m_cnt);
            m_pulse <= (nx == 3) && (m_state != 3);
            if (nx == 2 && m_state != 2) m_cnt <= int'(delay_etu);
            else if (m_state == 2 && etu_tick && m_cnt != 0) m_cnt <= m_cnt - 1;
            m_state <= nx;
        end
    end

    task automatic check(string req, string what, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // one clock edge, then compare at the falling edge
    task automatic edge_cmp();
        @(posedge clk);
        @(negedge clk);
        check(cur_req, "card_rst_n", int'(card_rst_n), (m_state == 3) ? 1 : 0);
        check(cur_req, "release_pulse", int'(release_pulse), int'(m_pulse));
    endtask

    // clears hold, ticks every other cycle, returns ticks used until release
    task automatic release_after_hold(output int ticks);
        hold_req = 1'b0; etu_tick = 1'b0;
        edge_cmp();
        ticks = 0;
        for (int k = 0; k < 1200 && !card_rst_n; k++) begin
            etu_tick = k[0];
            if (etu_tick) ticks++;
            edge_cmp();
        end
        etu_tick = 1'b0;
    endtask

    task automatic power_down();
        supply_ok = 1'b0; supply_en = 1'b0; hold_req = 1'b0; etu_tick = 1'b0;
        edge_cmp();
    endtask

    int ticks;
    int rnd;

    initial begin
        void'($urandom(32'h5EED_1234));
        @(negedge clk);
        cur_req = "R1";
        check("R1", "card_rst_n in reset", int'(card_rst_n), 0);
        check("R8", "release_pulse in reset", int'(release_pulse), 0);
        rst_n = 1'b1;
        edge_cmp();

        // R2: zero delay, release on the supply-good edge
        cur_req = "R2";
        delay_etu = 8'd0; supply_en = 1'b1;
        edge_cmp();
        check("R1", "low while supply_ok low", int'(card_rst_n), 0);
        supply_ok = 1'b1;
        edge_cmp();
        check("R2", "released on power-good edge", int'(card_rst_n), 1);
        check("R8", "pulse on release", int'(release_pulse), 1);
        edge_cmp();
        check("R8", "pulse lasts one cycle", int'(release_pulse), 0);

        // R4: hold from RELEASED
        cur_req = "R4";
        hold_req = 1'b1;
        edge_cmp();
        check("R4", "hold drives low", int'(card_rst_n), 0);

        // R5: clear hold with delay 3
        cur_req = "R5";
        delay_etu = 8'd3;
        release_after_hold(ticks);
        check("R5", "ticks to release after hold clear", ticks, 3);
        check("R5", "released", int'(card_rst_n), 1);

        // R5 zero delay: released on the clearing edge
        hold_req = 1'b1; edge_cmp();
        delay_etu = 8'd0; hold_req = 1'b0; edge_cmp();
        check("R5", "zero delay release on clear", int'(card_rst_n), 1);

        // R1: power loss
        cur_req = "R1";
        supply_ok = 1'b0; edge_cmp();
        check("R1", "power loss forces low", int'(card_rst_n), 0);

        // R3: power-up with delay 5
        cur_req = "R3";
        power_down();
        delay_etu = 8'd5; supply_en = 1'b1; supply_ok = 1'b1; etu_tick = 1'b1;
        edge_cmp();
        check("R3", "low after entering count", int'(card_rst_n), 0);
        ticks = 0;
        for (int k = 0; k < 200 && !card_rst_n; k++) begin
            etu_tick = (k % 3 == 2);
            if (etu_tick) ticks++;
            edge_cmp();
        end
        etu_tick = 1'b0;
        check("R3", "ticks counted in COUNT", ticks, 5);

        // R6: hold before power, stays low
        cur_req = "R6";
        power_down();
        hold_req = 1'b1; delay_etu = 8'd0;
        edge_cmp();
        supply_en = 1'b1; supply_ok = 1'b1;
        for (int k = 0; k < 40; k++) begin
            etu_tick = k[0];
            edge_cmp();
            if (k == 39) check("R6", "held through power-up", int'(card_rst_n), 0);
        end
        delay_etu = 8'd4;
        release_after_hold(ticks);
        check("R6", "ticks after late clear", ticks, 4);

        // R7: abort during count, full restart
        cur_req = "R7";
        hold_req = 1'b1; edge_cmp();
        delay_etu = 8'd6;
        hold_req = 1'b0; edge_cmp();
        for (int k = 0; k < 4; k++) begin etu_tick = 1'b1; edge_cmp(); end
        etu_tick = 1'b0;
        hold_req = 1'b1; edge_cmp();
        check("R7", "abort keeps low", int'(card_rst_n), 0);
        release_after_hold(ticks);
        check("R7", "full delay after abort", ticks, 6);

        // R9: delay changed mid-count
        cur_req = "R9";
        hold_req = 1'b1; edge_cmp();
        delay_etu = 8'd4; hold_req = 1'b0; edge_cmp();
        delay_etu = 8'd1;
        ticks = 0;
        for (int k = 0; k < 100 && !card_rst_n; k++) begin
            etu_tick = k[0];
            if (etu_tick) ticks++;
            edge_cmp();
        end
        etu_tick = 1'b0;
        check("R9", "captured delay used", ticks, 4);

        // R8 with the maximum delay
        cur_req = "R8";
        hold_req = 1'b1; edge_cmp();
        delay_etu = 8'd255;
        release_after_hold(ticks);
        check("R3", "maximum delay ticks", ticks, 255);
        check("R8", "pulse at max-delay release", int'(release_pulse), 1);

        // random phase
        cur_req = "R1/R3/R4/R7/R8";
        for (int k = 0; k < 4000; k++) begin
            rnd = int'($urandom % 64);
            if (rnd == 0) supply_ok = ~supply_ok;
            if (rnd == 1) supply_en = ~supply_en;
            if (rnd >= 2 && rnd < 5) hold_req = ~hold_req;
            if (rnd == 5) delay_etu = 8'($urandom % 8);
            if (rnd == 6) delay_etu = 8'($urandom);
            etu_tick = ($urandom % 3) == 0;
            edge_cmp();
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end
endmodule